// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the hazard-detection and operand-bypass control for an in-order processor with five stages: fetch, decode, execute, memory and write-back. Every cycle it reads the two source register IDs of the instruction in decode. It also reads the destination IDs and result values that the later stages are carrying. From these it builds both decode operands, each taken either from the newest in-flight producer or from the register file read ports. The block is combinational. The clock and reset inputs are used only to sample its assertions.

It also drives the hold (stall) and squash (bubble) controls of the pipeline registers. A load whose result is needed at once holds fetch and decode for one cycle and puts a bubble into execute. A return in flight holds fetch until its target has been read from memory. A mispredicted conditional jump found in execute squashes decode and execute. A bad status in memory or write-back stops further side effects. The priorities between these cases are fixed, so any mix of inputs gives one well-defined set of controls.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: Operand A is taken from the first match in this order: execute ALU result (code 1), memory loaded value (code 2), memory ALU result (code 3), write-back loaded value (code 4), write-back ALU result (code 5), and otherwise the register file (code 0). A match means the destination ID equals the source ID. The code is shown on `sel_a`.
- R2: Operand B follows the same order and codes on `sel_b`, independently of operand A.
- R3: Register ID 4'hF means "no register". It never matches, so a source ID of 4'hF always selects code 0.
- R4: `opnd_a` and `opnd_b` equal the value of the source that `sel_a` and `sel_b` name.
- R5: Load/use hazard: `e_dst_m` is not 4'hF and equals either decode source. This raises `f_stall`, `d_stall` and `e_bubble`.
- R6: When a return is in decode, execute or memory, `f_stall` and `d_bubble` are raised.
- R7: When a load/use hazard and a pending return occur together, decode is stalled and not bubbled.
- R8: `e_mispredict` raises `d_bubble` and `e_bubble` and clears `d_stall`.
- R9: A bad status in memory or write-back raises `m_bubble`. A bad status in write-back also raises `w_stall`.
- R10: With no hazard, every stall and bubble output is 0, and `d_stall` and `d_bubble` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for checks |
| rst_n | input | 1 | Active-low reset for checks |
| d_src_a | input | 4 | Decode source ID A |
| d_src_b | input | 4 | Decode source ID B |
| rf_a | input | XLEN | Register file value for A |
| rf_b | input | XLEN | Register file value for B |
| d_ret | input | 1 | Return in decode |
| e_ret | input | 1 | Return in execute |
| m_ret | input | 1 | Return in memory |
| e_dst_e | input | 4 | Execute ALU destination |
| e_dst_m | input | 4 | Execute load destination |
| e_val_e | input | XLEN | Execute ALU result |
| e_mispredict | input | 1 | Conditional jump in execute was mispredicted |
| m_dst_e | input | 4 | Memory-stage ALU destination |
| m_dst_m | input | 4 | Memory-stage load destination |
| m_val_e | input | XLEN | Memory-stage ALU result |
| m_val_m | input | XLEN | Memory-stage loaded value |
| m_bad | input | 1 | Memory-stage status not OK |
| w_dst_e | input | 4 | Write-back ALU destination |
| w_dst_m | input | 4 | Write-back load destination |
| w_val_e | input | XLEN | Write-back ALU result |
| w_val_m | input | XLEN | Write-back loaded value |
| w_bad | input | 1 | Write-back status not OK |
| opnd_a | output | XLEN | Bypassed operand A |
| opnd_b | output | XLEN | Bypassed operand B |
| sel_a | output | 3 | Source code of operand A |
| sel_b | output | 3 | Source code of operand B |
| f_stall | output | 1 | Hold fetch register |
| d_stall | output | 1 | Hold decode register |
| d_bubble | output | 1 | Squash decode register |
| e_bubble | output | 1 | Squash execute register |
| m_bubble | output | 1 | Squash memory register |
| w_stall | output | 1 | Hold write-back register |

## Verification
The bypass path is swept over every combination of the two source IDs and the five destination IDs. Each ID is drawn from two real registers and the "no register" code. This separates a match from a miss and shows that the priority order decides when several producers share a register. It also shows that the ID 4'hF never takes part in a match. Each candidate source carries a distinct value, so a wrong selection shows up in the operand even when the code happens to look right. The control path is swept over all combinations of load/use, the three return flags, mispredict and the two status flags, which exposes each priority overlap between the cases.

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl #(
  parameter int XLEN = 64,
  parameter int RIDW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RIDW-1:0] d_src_a,
  input  logic [RIDW-1:0] d_src_b,
  input  logic [XLEN-1:0] rf_a,
  input  logic [XLEN-1:0] rf_b,
  input  logic            d_ret,
  input  logic            e_ret,
  input  logic            m_ret,
  input  logic [RIDW-1:0] e_dst_e,
  input  logic [RIDW-1:0] e_dst_m,
  input  logic [XLEN-1:0] e_val_e,
  input  logic            e_mispredict,
  input  logic [RIDW-1:0] m_dst_e,
  input  logic [RIDW-1:0] m_dst_m,
  input  logic [XLEN-1:0] m_val_e,
  input  logic [XLEN-1:0] m_val_m,
  input  logic            m_bad,
  input  logic [RIDW-1:0] w_dst_e,
  input  logic [RIDW-1:0] w_dst_m,
  input  logic [XLEN-1:0] w_val_e,
  input  logic [XLEN-1:0] w_val_m,
  input  logic            w_bad,
  output logic [XLEN-1:0] opnd_a,
  output logic [XLEN-1:0] opnd_b,
  output logic [2:0]      sel_a,
  output logic [2:0]      sel_b,
  output logic            f_stall,
  output logic            d_stall,
  output logic            d_bubble,
  output logic            e_bubble,
  output logic            m_bubble,
  output logic            w_stall
);

  localparam logic [RIDW-1:0] NOREG = '1;

  function automatic logic hit(input logic [RIDW-1:0] src, input logic [RIDW-1:0] dst);
    return (src != NOREG) && (src == dst);
  endfunction

  function automatic logic [2:0] pick(input logic [RIDW-1:0] src);
    if (hit(src, e_dst_e))      return 3'd1;
    else if (hit(src, m_dst_m)) return 3'd2;
    else if (hit(src, m_dst_e)) return 3'd3;
    else if (hit(src, w_dst_m)) return 3'd4;
    else if (hit(src, w_dst_e)) return 3'd5;
    else                        return 3'd0;
  endfunction

  function automatic logic [XLEN-1:0] route(input logic [2:0] s, input logic [XLEN-1:0] rf);
    case (s)
      3'd1:    return e_val_e;
      3'd2:    return m_val_m;
      3'd3:    return m_val_e;
      3'd4:    return w_val_m;
      3'd5:    return w_val_e;
      default: return rf;
    endcase
  endfunction

  assign sel_a  = pick(d_src_a);
  assign sel_b  = pick(d_src_b);
  assign opnd_a = route(sel_a, rf_a);
  assign opnd_b = route(sel_b, rf_b);

  logic load_use, ret_wait;
  assign load_use = hit(d_src_a, e_dst_m) || hit(d_src_b, e_dst_m);
  assign ret_wait = d_ret || e_ret || m_ret;

  assign f_stall  = load_use || ret_wait;
  assign d_stall  = load_use && !e_mispredict;
  assign d_bubble = e_mispredict || (ret_wait && !load_use);
  assign e_bubble = e_mispredict || load_use;
  assign m_bubble = m_bad || w_bad;
  assign w_stall  = w_bad;

  AST_SEL_A_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    sel_a == 3'd1 |-> opnd_a == e_val_e);                         // R4
  AST_NOREG_A: assert property (@(posedge clk) disable iff (!rst_n)
    d_src_a == NOREG |-> sel_a == 3'd0 && opnd_a == rf_a);        // R3
  AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (e_dst_m != NOREG && e_dst_m == d_src_b) |-> f_stall && e_bubble); // R5
  AST_RET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (d_ret || e_ret || m_ret) |-> f_stall && (d_stall || d_bubble));    // R6
  AST_MISPRED: assert property (@(posedge clk) disable iff (!rst_n)
    e_mispredict |-> d_bubble && e_bubble && !d_stall);           // R8
  AST_BAD_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (m_bad || w_bad) |-> m_bubble);                               // R9
  AST_D_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(d_stall && d_bubble));                                      // R10

endmodule

// File: tb/pipe_hazard_ctl_tb.sv
module pipe_hazard_ctl_tb_top;
  localparam int XLEN = 64;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [3:0] d_src_a, d_src_b, e_dst_e, e_dst_m, m_dst_e, m_dst_m, w_dst_e, w_dst_m;
  logic [XLEN-1:0] rf_a, rf_b, e_val_e, m_val_e, m_val_m, w_val_e, w_val_m;
  logic d_ret, e_ret, m_ret, e_mispredict, m_bad, w_bad;
  logic [XLEN-1:0] opnd_a, opnd_b;
  logic [2:0] sel_a, sel_b;
  logic f_stall, d_stall, d_bubble, e_bubble, m_bubble, w_stall;

  int vecs = 0, errs = 0;

  pipe_hazard_ctl #(.XLEN(XLEN), .RIDW(4)) dut_i (.*);

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] idsel(input int k);
    return (k == 0) ? 4'd1 : (k == 1) ? 4'd2 : 4'hF;
  endfunction

  task automatic ref_fwd(input logic [3:0] s, input logic [XLEN-1:0] rf,
                         output logic [2:0] c, output logic [XLEN-1:0] v);
    logic [3:0] dl[5];
    logic [XLEN-1:0] vl[5];
    dl = '{e_dst_e, m_dst_m, m_dst_e, w_dst_m, w_dst_e};
    vl = '{e_val_e, m_val_m, m_val_e, w_val_m, w_val_e};
    c = 0; v = rf;
    for (int i = 4; i >= 0; i--)
      if (s != 4'hF && dl[i] == s) begin c = 3'(i + 1); v = vl[i]; end
  endtask

  task automatic idle();
    d_src_a = 4'hF; d_src_b = 4'hF; e_dst_e = 4'hF; e_dst_m = 4'hF;
    m_dst_e = 4'hF; m_dst_m = 4'hF; w_dst_e = 4'hF; w_dst_m = 4'hF;
    d_ret = 0; e_ret = 0; m_ret = 0; e_mispredict = 0; m_bad = 0; w_bad = 0;
    rf_a = 64'hA0A0; rf_b = 64'hB0B0; e_val_e = 64'h1111; m_val_m = 64'h2222;
    m_val_e = 64'h3333; w_val_m = 64'h4444; w_val_e = 64'h5555;
  endtask

  initial begin
    #200000;
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [2:0] ec;
    logic [XLEN-1:0] ev;
    idle();
    #3;
    chk("R10 reset f_stall", XLEN'(f_stall), 0);
    chk("R10 reset d_bubble", XLEN'(d_bubble), 0);
    chk("R3 reset sel_a", XLEN'(sel_a), 0);
    chk("R4 reset opnd_b", opnd_b, 64'hB0B0);
    repeat (2) @(posedge clk);
    rst_n = 1;

    // R1 R2 R3 R4: bypass sweep
    for (int a = 0; a < 3; a++)
    for (int b = 0; b < 3; b++)
    for (int p = 0; p < 243; p++) begin
      @(negedge clk);
      idle();
      d_src_a = idsel(a); d_src_b = idsel(b);
      e_dst_e = idsel(p % 3);       m_dst_m = idsel((p / 3) % 3);
      m_dst_e = idsel((p / 9) % 3); w_dst_m = idsel((p / 27) % 3);
      w_dst_e = idsel((p / 81) % 3);
      #1;
      ref_fwd(d_src_a, rf_a, ec, ev);
      chk("R1 sel_a", XLEN'(sel_a), XLEN'(ec));
      chk("R4 opnd_a", opnd_a, ev);
      if (a == 2) chk("R3 sel_a none", XLEN'(sel_a), 0);
      ref_fwd(d_src_b, rf_b, ec, ev);
      chk("R2 sel_b", XLEN'(sel_b), XLEN'(ec));
      chk("R4 opnd_b", opnd_b, ev);
    end

    // R5..R10: control sweep
    for (int m = 0; m < 256; m++) begin
      logic lu, rt, mp, mb, wb;
      @(negedge clk);
      idle();
      d_src_a = 4'd3; d_src_b = 4'd4;
      case (m & 3)
        0: e_dst_m = 4'hF;
        1: e_dst_m = 4'd3;
        2: e_dst_m = 4'd4;
        default: e_dst_m = 4'd7;
      endcase
      d_ret = m[2]; e_ret = m[3]; m_ret = m[4];
      e_mispredict = m[5]; m_bad = m[6]; w_bad = m[7];
      #1;
      lu = ((m & 3) == 1) || ((m & 3) == 2);
      rt = m[2] | m[3] | m[4];
      mp = m[5]; mb = m[6]; wb = m[7];
      chk("R5 R6 f_stall", XLEN'(f_stall), XLEN'(lu | rt));
      chk("R5 R8 d_stall", XLEN'(d_stall), XLEN'(lu & ~mp));
      chk("R6 R7 R8 d_bubble", XLEN'(d_bubble), XLEN'(mp | (rt & ~lu)));
      chk("R5 R8 e_bubble", XLEN'(e_bubble), XLEN'(lu | mp));
      chk("R9 m_bubble", XLEN'(m_bubble), XLEN'(mb | wb));
      chk("R9 w_stall", XLEN'(w_stall), XLEN'(wb));
      chk("R10 d excl", XLEN'(d_stall & d_bubble), 0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule